// File: doc/BRIEF.md
# Input Capture Noise Filter

This block cleans up the timer's asynchronous capture pins before they reach the input-capture logic. Each pin first passes through a two-flop synchronizer on the system clock. It then enters a three-deep sample shift register that advances only on a sampling strobe. The filtered level changes only when all three samples agree. When they disagree, the previous level is held. A pulse that lasts at least three sampling periods therefore passes, and a shorter one is dropped as noise.

All channels share one sampling-rate generator. It produces a strobe every system clock, every eighth or every thirty-second clock, or whenever the timer's count-clock enable pulses. Each channel can bypass its filter and forward the synchronized level instead. The selected level of every channel feeds an edge detector, which emits single-cycle rise and fall pulses for the capture logic.

Top module: `capture_noise_filter`

## Requirements
- R1: While reset is asserted and in the cycle it is released, every filtered output, rise pulse and fall pulse is 0. All sample flops and the divider counter start from 0.
- R2: With `rate_sel` = 00 (a strobe every clock), a level change driven between rising edges e0 and e0+1 appears on `sig_out` after edge e0+5 and not before.
- R3: A pulse shorter than three sampling periods never reaches `sig_out`. For example, at `rate_sel` = 00 a 1- or 2-cycle pulse is dropped.
- R4: When the three samples all hold the same level, `sig_out` takes that level. A pulse of exactly three sampling periods appears with its width preserved.
- R5: When the three samples disagree, `sig_out` keeps its previous value.
- R6: With `rate_sel` = 01 a strobe falls on every 8th rising edge after reset release (edges 8, 16, 24, ...). With `rate_sel` = 10 it falls on every 32nd edge (32, 64, 96, ...). Samples move only on those edges.
- R7: With `rate_sel` = 11 the samples advance only on edges where `ext_cnt_stb` is 1. With that input held at 0, `sig_out` never changes.
- R8: When `filt_en[i]` = 0, `sig_out[i]` is the synchronized pin, two clocks after the pin. Even a one-cycle pulse passes.
- R9: `rise_pls[i]` is 1 for exactly one clock in the cycle `sig_out[i]` goes 0 to 1. `fall_pls[i]` does the same for a 1-to-0 change.
- R10: The channels filter independently under the shared rate. Transitions on different channels in the same cycle give their pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Sampling rate: 00 every clock, 01 every 8, 10 every 32, 11 external strobe |
| ext_cnt_stb | input | 1 | Single-cycle timer count-clock enable, used when rate_sel = 11 |
| filt_en | input | NCH | Per-channel filter enable (0 = bypass) |
| pin_in | input | NCH | Asynchronous capture pins |
| sig_out | output | NCH | Selected (filtered or bypassed) level per channel |
| rise_pls | output | NCH | One-cycle rising-edge pulse per channel |
| fall_pls | output | NCH | One-cycle falling-edge pulse per channel |

## Verification
A rising edge on one channel and a falling edge on another can land in the same cycle. They share the sampling strobe but not the sample registers. The bench drives one pin from 0 to 1 and another from 1 to 0 at the same clock. It then expects, five cycles later, a rise pulse on the first and a fall pulse on the second in the same cycle, with all other pulse bits quiet before and after. A bypassed channel's one-cycle pulse is also run next to filtered channels, so that the bypass path and the filter path are judged side by side.

// File: rtl/capf_pkg.sv
package capf_pkg;

  typedef enum logic [1:0] {
    RATE_FULL  = 2'b00,
    RATE_DIV_A = 2'b01,
    RATE_DIV_B = 2'b10,
    RATE_EXT   = 2'b11
  } rate_sel_e;

  // Three samples agree when they are all low or all high.
  function automatic logic all_agree(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b111);
  endfunction

  // Last cycle of a power-of-two period for a free-running count.
  function automatic logic phase_end(input int unsigned cnt, input int unsigned div);
    return (cnt & (div - 1)) == (div - 1);
  endfunction

endpackage

// File: rtl/capf_rate_gen.sv
module capf_rate_gen
  import capf_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       ext_stb,
  output logic       samp_stb
);
  localparam int CW = $clog2(DIV_B);

  logic [CW-1:0] cnt_q;
  rate_sel_e     sel_e;
  logic          end_a;
  logic          end_b;

  assign sel_e = rate_sel_e'(rate_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign end_a = phase_end(32'(cnt_q), DIV_A);
  assign end_b = phase_end(32'(cnt_q), DIV_B);

  always_comb begin
    unique case (sel_e)
      RATE_FULL:  samp_stb = 1'b1;
      RATE_DIV_A: samp_stb = end_a;
      RATE_DIV_B: samp_stb = end_b;
      default:    samp_stb = ext_stb;
    endcase
  end

  // Divided strobes never come on two cycles in a row.
  assert_div_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == RATE_DIV_A && $past(sel_e) == RATE_DIV_A && samp_stb) |-> !$past(samp_stb));

endmodule

// File: rtl/capf_chan.sv
module capf_chan
  import capf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_stb,
  input  logic pin,
  input  logic filt_en,
  output logic sel_out
);
  logic [1:0] sync_q;
  logic       sync_lvl;
  logic [2:0] samp_q;     // bit 0 newest
  logic [2:0] samp_next;
  logic       filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin};
  end
  assign sync_lvl = sync_q[1];

  assign samp_next = {samp_q[1:0], sync_lvl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= '0;
      filt_q <= 1'b0;
    end else if (samp_stb) begin
      samp_q <= samp_next;
      if (all_agree(samp_next)) filt_q <= samp_next[0];
    end
  end

  assign sel_out = filt_en ? filt_q : sync_lvl;

  // The filtered level only moves to a level held by all three samples.
  assert_change_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (all_agree(samp_q) && samp_q[0] == filt_q));

  // Without a strobe nothing in the sampler moves.
  assert_hold_without_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_stb |=> ($stable(samp_q) && $stable(filt_q)));

endmodule

// File: rtl/capf_edge.sv
module capf_edge #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/capture_noise_filter.sv
module capture_noise_filter #(
  parameter int          NCH   = 4,
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     rate_sel,
  input  logic           ext_cnt_stb,
  input  logic [NCH-1:0] filt_en,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] sig_out,
  output logic [NCH-1:0] rise_pls,
  output logic [NCH-1:0] fall_pls
);
  logic samp_stb;

  capf_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .ext_stb  (ext_cnt_stb),
    .samp_stb (samp_stb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    capf_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_stb (samp_stb),
      .pin      (pin_in[i]),
      .filt_en  (filt_en[i]),
      .sel_out  (sig_out[i])
    );

    assert_rise_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pls[i] |-> (sig_out[i] && !$past(sig_out[i])));
    assert_fall_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pls[i] |-> (!sig_out[i] && $past(sig_out[i])));
  end

  capf_edge #(.NCH(NCH)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sig_out),
    .rise  (rise_pls),
    .fall  (fall_pls)
  );

endmodule

// File: tb/sim_capture_noise_filter.sv
module sim_capture_noise_filter;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     rate_sel = 2'b00;
  logic           ext_cnt_stb = 1'b0;
  logic [NCH-1:0] filt_en = '1;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] sig_out, rise_pls, fall_pls;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  capture_noise_filter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_cnt_stb(ext_cnt_stb),
    .filt_en(filt_en), .pin_in(pin_in), .sig_out(sig_out),
    .rise_pls(rise_pls), .fall_pls(fall_pls)
  );

  // Vector fields: pins[11:8], hold cycles[7:4], expected sig_out[3:0].
  // Rate every clock, all filters on; each hold ends at a negedge.
  localparam int NV = 11;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {4'b0101, 4'd8, 4'b0101},
    {4'b1010, 4'd8, 4'b1010},
    {4'b1111, 4'd2, 4'b1010},
    {4'b1010, 4'd6, 4'b1010},
    {4'b0000, 4'd3, 4'b1010},
    {4'b1010, 4'd3, 4'b0000},
    {4'b1010, 4'd3, 4'b1010},
    {4'b0110, 4'd8, 4'b0110},
    {4'b0000, 4'd1, 4'b0110},
    {4'b0110, 4'd7, 4'b0110},
    {4'b1001, 4'd5, 4'b1001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, pins already high
    pin_in = 4'b1111;
    do_reset();
    chk("R1 sig_out", 32'(sig_out), 0);
    chk("R1 rise", 32'(rise_pls), 0);
    chk("R1 fall", 32'(fall_pls), 0);

    // Vector walk: latency, rejection, pass, hold (R2/R3/R4/R5)
    pin_in = '0;
    do_reset();
    step(8);
    for (int k = 0; k < NV; k++) begin
      pin_in = VEC[k][11:8];
      step(int'(VEC[k][7:4]));
      chk($sformatf("R2/R3/R4/R5 vector %0d", k), 32'(sig_out), 32'(VEC[k][3:0]));
    end

    // R2 exact latency, R9 single-cycle pulses
    pin_in = 4'b0000;
    step(8);
    pin_in = 4'b0001;
    step(4);
    chk("R2 before latency", 32'(sig_out), 0);
    step(1);
    chk("R2 at latency", 32'(sig_out), 1);
    chk("R9 rise pulse", 32'(rise_pls), 1);
    step(1);
    chk("R9 rise one cycle", 32'(rise_pls), 0);
    pin_in = 4'b0000;
    step(5);
    chk("R9 fall pulse", 32'(fall_pls), 1);
    step(1);
    chk("R9 fall one cycle", 32'(fall_pls), 0);

    // R10 rise and fall on different channels in one cycle
    pin_in = 4'b0100;
    step(8);
    pin_in = 4'b0010;
    step(4);
    chk("R10 no early pulse", 32'({rise_pls, fall_pls}), 0);
    step(1);
    chk("R10 rise ch1", 32'(rise_pls), 32'h2);
    chk("R10 fall ch2", 32'(fall_pls), 32'h4);
    step(1);
    chk("R10 pulses cleared", 32'({rise_pls, fall_pls}), 0);

    // R6 divide by 8
    rate_sel = 2'b01;
    pin_in = 4'b0001;
    do_reset();
    step(16);
    chk("R6 div8 edge16", 32'(sig_out), 0);
    step(7);
    chk("R6 div8 edge23", 32'(sig_out), 0);
    step(1);
    chk("R6 div8 edge24", 32'(sig_out), 1);

    // R6 divide by 32
    rate_sel = 2'b10;
    do_reset();
    step(95);
    chk("R6 div32 edge95", 32'(sig_out), 0);
    step(1);
    chk("R6 div32 edge96", 32'(sig_out), 1);

    // R7 external strobe
    rate_sel = 2'b11;
    ext_cnt_stb = 1'b0;
    do_reset();
    step(20);
    chk("R7 no strobe no change", 32'(sig_out), 0);
    for (int k = 0; k < 3; k++) begin
      ext_cnt_stb = 1'b1;
      step(1);
      ext_cnt_stb = 1'b0;
      step(3);
      chk($sformatf("R7 after strobe %0d", k + 1), 32'(sig_out), (k == 2) ? 1 : 0);
    end

    // R8 bypass on channel 3 beside filtered channel 0
    rate_sel = 2'b00;
    filt_en = 4'b0111;
    pin_in = 4'b0000;
    do_reset();
    step(8);
    pin_in = 4'b1001;
    step(1);
    pin_in = 4'b0000;
    chk("R8 not yet", 32'(sig_out), 0);
    step(1);
    chk("R8 bypass passes", 32'(sig_out), 32'h8);
    chk("R8 rise bypass", 32'(rise_pls), 32'h8);
    step(1);
    chk("R8 bypass ends", 32'(sig_out), 0);
    chk("R8 fall bypass", 32'(fall_pls), 32'h8);
    step(4);
    chk("R3 filtered glitch dropped", 32'(sig_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule